// File: doc/BRIEF.md
# Field Delay Memory Write Port

This block is the write side of a field delay memory that is written and read by independent clocks. It runs in the write clock domain only. On each rising edge it may take one data word, steered by three controls: a pointer reset, a write enable that stalls both the pointer and the data capture, and an input enable that keeps the pointer moving but protects the addressed location. The input enable lets a new picture overwrite only part of a stored field, as in picture-in-picture.

Words are collected in a staging line of `LINE_WORDS` slots. A line is committed to the external storage array in one wide write. Each slot has its own byte enable, so masked slots keep their old contents in the array. The last, partly filled line of a field stays in the staging line until the next pointer reset flushes it. The block also checks two sequencing rules on the reset input and flags each breach with a one-cycle pulse. The full-size organisation is 512 x 512 words written in 256-word chunks (`DEPTH`=262144, `LINE_WORDS`=256). The defaults below are a small configuration for simulation.

Top module: `fm_wr_port`

## Requirements
- R1: Every rising edge with `rstw_i` high sets `wr_ptr_o` to 0 after that edge.
- R2: On an edge with `rstw_i` high, `we_i`, `ie_i` and `din_i` are ignored. No word is staged and the pointer does not advance. A reset with nothing staged produces no array write.
- R3: On an edge with `rstw_i` low and `we_i` high, `din_i` is captured into slot `wr_ptr_o mod LINE_WORDS` and `wr_ptr_o` advances by one. With `we_i` low, `wr_ptr_o` holds and nothing is captured.
- R4: A word written with `ie_i` low still advances the pointer, but its slot's bit in `arr_be_o` is 0 at commit time, so that array location keeps its previous value.
- R5: Writing slot `LINE_WORDS-1` commits the line if at least one of its slots is unmasked. For one cycle after that edge, `arr_we_o` is 1 and `arr_line_o` is `wr_ptr_o / LINE_WORDS` taken before the edge. `arr_data_o[k*DATA_W +: DATA_W]` holds slot k, and `arr_be_o[k]` is 1 exactly for the slots written with `ie_i` high.
- R6: A partly filled line is not committed until a reset edge. That edge commits it with the same line index and per-slot enables as in R5, provided at least one staged slot is unmasked.
- R7: `rst_err_o` pulses for one cycle after a reset edge when `rstw_i` was low for exactly one cycle since it was last high. After two or more low cycles, or while `rstw_i` is held high, it stays 0.
- R8: `short_run_o` pulses for one cycle after a reset edge that follows a low `rstw_i` when fewer than `MIN_RUN` write cycles (`we_i` high, `rstw_i` low) occurred since the previous reset. It does not pulse on the first reset after `rst_ni`.
- R9: The pointer wraps from `DEPTH-1` to 0. The write of address `DEPTH-1` commits the last line, index `DEPTH/LINE_WORDS-1`.
- R10: While `rst_ni` is low, `wr_ptr_o`, `arr_we_o`, `rst_err_o` and `short_run_o` are 0 and the staging line is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rstw_i | input | 1 | Pointer reset, sampled on the clock edge |
| we_i | input | 1 | Write enable: capture the word and advance the pointer |
| ie_i | input | 1 | Input enable: 0 masks the store but not the pointer advance |
| din_i | input | 8 | Data word |
| wr_ptr_o | output | 10 | Current write address |
| arr_we_o | output | 1 | Array line write strobe |
| arr_line_o | output | 6 | Array line index |
| arr_data_o | output | 128 | Line data, slot k at bits k*8 and up |
| arr_be_o | output | 16 | Per-slot write enables |
| rst_err_o | output | 1 | Reset re-asserted too soon |
| short_run_o | output | 1 | Too few write cycles between resets |

## Verification
The hardest state to reach is a line that is half staged and half masked at the moment a reset arrives. The flush must then carry only the unmasked slots, and the array words beside them must survive. The bench first fills a line with a known pattern, then writes a few slots of that line, and then resets. It checks the flushed enables and every affected array word in a model memory that the bench keeps from the commit port. The wrap test drives a full `DEPTH` of writes so that the pointer crosses from its top address to zero at the same edge as the last line commit. The short-run flag is checked on both sides of its limit, after `MIN_RUN-1` writes and after `MIN_RUN` writes.

// File: rtl/fm_wr_pkg.sv
package fm_wr_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_WRITE = 2'd1,
    CYC_RESET = 2'd2
  } cyc_e;
endpackage

// File: rtl/fm_wr_ptr.sv
module fm_wr_ptr
  import fm_wr_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cyc_e             cyc_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;

  // DEPTH is a power of two, so the increment wraps by itself
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ptr_q <= '0;
    else if (cyc_i == CYC_RESET) ptr_q <= '0;
    else if (cyc_i == CYC_WRITE) ptr_q <= ptr_q + PTR_W'(1);
  end

  assign ptr_o = ptr_q;

  p_reset_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_i == CYC_RESET |=> ptr_o == '0);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_i == CYC_IDLE |=> $stable(ptr_o));
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_i == CYC_WRITE |=> ptr_o == $past(ptr_o) + PTR_W'(1));
  p_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i == CYC_WRITE && ptr_o == PTR_W'(DEPTH-1)) |=> ptr_o == '0);
endmodule

// File: rtl/fm_wr_proto.sv
module fm_wr_proto
  import fm_wr_pkg::*;
#(
  parameter int MIN_RUN = 80,
  localparam int RUN_W = $clog2(MIN_RUN+1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  cyc_e cyc_i,
  output logic rst_err_o,
  output logic short_run_o
);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MIN_RUN);

  logic [1:0]       low_q;   // low cycles since last reset edge, saturating at 2
  logic [RUN_W-1:0] run_q;
  logic             armed_q;
  logic             is_rst, new_rst;

  assign is_rst  = (cyc_i == CYC_RESET);
  assign new_rst = is_rst && (low_q != 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q       <= 2'd2;
      run_q       <= '0;
      armed_q     <= 1'b0;
      rst_err_o   <= 1'b0;
      short_run_o <= 1'b0;
    end else begin
      rst_err_o   <= new_rst && (low_q == 2'd1);
      short_run_o <= new_rst && armed_q && (run_q < RUN_MAX);
      if (is_rst) begin
        low_q   <= 2'd0;
        run_q   <= '0;
        armed_q <= 1'b1;
      end else begin
        if (low_q != 2'd2) low_q <= low_q + 2'd1;
        if (cyc_i == CYC_WRITE && run_q != RUN_MAX) run_q <= run_q + RUN_W'(1);
      end
    end
  end

  p_err_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_err_o |-> $past(cyc_i) == CYC_RESET);
  p_err_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rst && low_q == 2'd0) |=> !rst_err_o);
  p_short_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_run_o |-> $past(cyc_i) == CYC_RESET);
  p_short_unarmed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> !short_run_o);
endmodule

// File: rtl/fm_wr_stage.sv
module fm_wr_stage
  import fm_wr_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LINE_WORDS = 16,
  parameter int LINE_AW    = 6,
  localparam int LINE_LG   = $clog2(LINE_WORDS),
  localparam int LINE_BW   = LINE_WORDS*DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  cyc_e               cyc_i,
  input  logic [LINE_LG-1:0] slot_i,
  input  logic [LINE_AW-1:0] line_i,
  input  logic               ie_i,
  input  logic [DATA_W-1:0]  din_i,
  output logic               arr_we_o,
  output logic [LINE_AW-1:0] arr_line_o,
  output logic [LINE_BW-1:0] arr_data_o,
  output logic [LINE_WORDS-1:0] arr_be_o
);
  logic [LINE_BW-1:0]    nxt_data;
  logic [LINE_WORDS-1:0] nxt_be, stg_be;
  logic                  last_slot, commit;

  assign last_slot = (cyc_i == CYC_WRITE) && (slot_i == LINE_LG'(LINE_WORDS-1));
  // all-masked lines are dropped: the array would not change
  assign commit = (last_slot || cyc_i == CYC_RESET) && (|nxt_be);

  for (genvar k = 0; k < LINE_WORDS; k++) begin : g_slot
    logic [DATA_W-1:0] word_q;
    logic              hit;

    assign hit = (cyc_i == CYC_WRITE) && (slot_i == LINE_LG'(k));
    assign nxt_data[k*DATA_W +: DATA_W] = hit ? din_i : word_q;
    assign nxt_be[k] = hit ? ie_i : stg_be[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q    <= '0;
        stg_be[k] <= 1'b0;
      end else begin
        word_q    <= nxt_data[k*DATA_W +: DATA_W];
        stg_be[k] <= (commit || cyc_i == CYC_RESET) ? 1'b0 : nxt_be[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arr_we_o   <= 1'b0;
      arr_line_o <= '0;
      arr_data_o <= '0;
      arr_be_o   <= '0;
    end else begin
      arr_we_o <= commit;
      if (commit) begin
        arr_line_o <= line_i;
        arr_data_o <= nxt_data;
        arr_be_o   <= nxt_be;
      end
    end
  end

  p_commit_nonempty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> arr_be_o != '0);
  p_commit_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> $past(cyc_i) != CYC_IDLE);
  p_flush_empties_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_i == CYC_RESET |=> stg_be == '0);
  p_reset_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i == CYC_RESET && stg_be == '0) |=> !arr_we_o);
endmodule

// File: rtl/fm_wr_port.sv
module fm_wr_port
  import fm_wr_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 1024,
  parameter int LINE_WORDS = 16,
  parameter int MIN_RUN    = 80,
  localparam int PTR_W     = $clog2(DEPTH),
  localparam int LINE_LG   = $clog2(LINE_WORDS),
  localparam int LINE_AW   = PTR_W - LINE_LG,
  localparam int LINE_BW   = LINE_WORDS*DATA_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rstw_i,
  input  logic                  we_i,
  input  logic                  ie_i,
  input  logic [DATA_W-1:0]     din_i,
  output logic [PTR_W-1:0]      wr_ptr_o,
  output logic                  arr_we_o,
  output logic [LINE_AW-1:0]    arr_line_o,
  output logic [LINE_BW-1:0]    arr_data_o,
  output logic [LINE_WORDS-1:0] arr_be_o,
  output logic                  rst_err_o,
  output logic                  short_run_o
);
  cyc_e cyc;

  // reset wins over write; enables are ignored in a reset cycle
  assign cyc = rstw_i ? CYC_RESET : (we_i ? CYC_WRITE : CYC_IDLE);

  fm_wr_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cyc_i (cyc),
    .ptr_o (wr_ptr_o)
  );

  fm_wr_stage #(
    .DATA_W    (DATA_W),
    .LINE_WORDS(LINE_WORDS),
    .LINE_AW   (LINE_AW)
  ) u_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cyc_i     (cyc),
    .slot_i    (wr_ptr_o[LINE_LG-1:0]),
    .line_i    (wr_ptr_o[PTR_W-1:LINE_LG]),
    .ie_i      (ie_i),
    .din_i     (din_i),
    .arr_we_o  (arr_we_o),
    .arr_line_o(arr_line_o),
    .arr_data_o(arr_data_o),
    .arr_be_o  (arr_be_o)
  );

  fm_wr_proto #(.MIN_RUN(MIN_RUN)) u_proto (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_i      (cyc),
    .rst_err_o  (rst_err_o),
    .short_run_o(short_run_o)
  );

  p_line_index_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !rstw_i && wr_ptr_o[LINE_LG-1:0] == LINE_LG'(LINE_WORDS-1) && ie_i)
      |=> arr_we_o && arr_line_o == $past(wr_ptr_o[PTR_W-1:LINE_LG]));
  p_masked_slot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !rstw_i && !ie_i && wr_ptr_o[LINE_LG-1:0] == LINE_LG'(LINE_WORDS-1))
      |=> !arr_we_o || !arr_be_o[LINE_WORDS-1]);
endmodule

// File: tb/fm_wr_port_test.sv
module fm_wr_port_test;
  localparam int DEPTH = 1024;
  localparam int LW    = 16;
  localparam int MINR  = 80;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rstw = 1'b0, we = 1'b0, ie = 1'b0;
  logic [7:0]   din = '0;
  logic [9:0]   wr_ptr;
  logic         arr_we;
  logic [5:0]   arr_line;
  logic [127:0] arr_data;
  logic [15:0]  arr_be;
  logic         rst_err, short_run;

  int checks = 0, failures = 0, cyc_cnt = 0;
  bit done = 0;

  // bench-side expectation state
  int e_ptr = 0, e_low = 2, e_run = 0;
  bit e_armed = 0;
  bit l_we, l_err, l_short;
  logic [5:0]  l_line;
  logic [15:0] l_be;
  logic [7:0]  mem [DEPTH];

  always #2.5 clk = ~clk;

  fm_wr_port uut (
    .clk_i(clk), .rst_ni(rst_n), .rstw_i(rstw), .we_i(we), .ie_i(ie), .din_i(din),
    .wr_ptr_o(wr_ptr), .arr_we_o(arr_we), .arr_line_o(arr_line), .arr_data_o(arr_data),
    .arr_be_o(arr_be), .rst_err_o(rst_err), .short_run_o(short_run)
  );

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog: run hung, act=%0d exp<100000 cycles", cyc_cnt);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample at the next negedge
  task automatic step(input bit r, input bit w, input bit e, input logic [7:0] d);
    bit x_err, x_short, nw;
    x_err = 0; x_short = 0;
    if (r) begin
      nw = (e_low != 0);
      x_err = nw && (e_low == 1);
      x_short = nw && e_armed && (e_run < MINR);
      e_ptr = 0; e_run = 0; e_low = 0; e_armed = 1;
    end else begin
      if (e_low < 2) e_low++;
      if (w) begin
        e_ptr = (e_ptr + 1) % DEPTH;
        if (e_run < MINR) e_run++;
      end
    end
    rstw = r; we = w; ie = e; din = d;
    @(posedge clk);
    @(negedge clk);
    chk(wr_ptr == 10'(e_ptr), "R3 pointer", wr_ptr, e_ptr);
    chk(rst_err == x_err, "R7 rst_err", rst_err, x_err);
    chk(short_run == x_short, "R8 short_run", short_run, x_short);
    l_we = arr_we; l_line = arr_line; l_be = arr_be; l_err = rst_err; l_short = short_run;
    if (arr_we)
      for (int k = 0; k < LW; k++)
        if (arr_be[k]) mem[int'(arr_line)*LW + k] = arr_data[k*8 +: 8];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00);
  endtask

  task automatic t_reset_state();
    chk(wr_ptr == 0, "R10 ptr in reset", wr_ptr, 0);
    chk(arr_we == 0 && rst_err == 0 && short_run == 0, "R10 outputs in reset",
        {arr_we, rst_err, short_run}, 0);
  endtask

  task automatic t_first_reset();
    step(1, 1, 1, 8'hAA);
    chk(l_we == 0, "R2 reset with we/ie high, no commit", l_we, 0);
    chk(wr_ptr == 0, "R1 ptr cleared", wr_ptr, 0);
    idle(2);
  endtask

  task automatic t_full_line();
    bit ok;
    for (int i = 0; i < LW; i++) begin
      step(0, 1, 1, 8'(8'h30 + i));
      if (i < LW-1) chk(l_we == 0, "R5 no early commit", l_we, 0);
    end
    chk(l_we == 1 && l_line == 0, "R5 line 0 commit", {l_we, l_line}, 7'h40);
    chk(l_be == 16'hFFFF, "R5 full enables", l_be, 16'hFFFF);
    ok = 1;
    for (int i = 0; i < LW; i++) if (mem[i] != 8'(8'h30 + i)) ok = 0;
    chk(ok, "R5 line 0 data", ok, 1);
  endtask

  task automatic t_we_hold();
    step(0, 0, 1, 8'hEE);
    step(0, 0, 0, 8'hEF);
    step(0, 0, 1, 8'hF0);
    chk(wr_ptr == 16 && l_we == 0, "R3 hold with we low", wr_ptr, 16);
    for (int i = 0; i < LW; i++) step(0, 1, 1, 8'(8'h50 + i));
    chk(l_we == 1 && l_line == 1, "R5 line 1 commit", {l_we, l_line}, 7'h41);
    chk(mem[16] == 8'h50, "R3 first word after hold", mem[16], 8'h50);
  endtask

  task automatic t_mask();
    bit ok;
    step(1, 0, 0, 8'h00);
    idle(2);
    for (int i = 0; i < LW; i++) step(0, 1, (i % 2) == 0, 8'(8'hC0 + i));
    chk(l_we == 1 && l_be == 16'h5555, "R4 masked enables", l_be, 16'h5555);
    ok = 1;
    for (int i = 0; i < LW; i++)
      if (mem[i] != ((i % 2 == 0) ? 8'(8'hC0 + i) : 8'(8'h30 + i))) ok = 0;
    chk(ok, "R4 masked words kept", ok, 1);
    chk(wr_ptr == 16, "R4 pointer advanced over masked", wr_ptr, 16);
  endtask

  task automatic t_partial();
    bit any;
    any = 0;
    for (int i = 0; i < 5; i++) begin
      step(0, 1, 1, 8'(8'h90 + i));
      if (l_we) any = 1;
    end
    chk(!any, "R6 partial line held", any, 0);
    step(1, 0, 0, 8'h00);
    chk(l_we == 1 && l_line == 1 && l_be == 16'h001F, "R6 flush on reset",
        {l_we, l_line, l_be}, {1'b1, 6'd1, 16'h001F});
    chk(mem[20] == 8'h94 && mem[21] == 8'h55, "R6 flushed data, neighbour kept",
        {mem[20], mem[21]}, 16'h9455);
    idle(2);
    for (int i = 0; i < 3; i++) step(0, 1, 0, 8'h11);
    step(1, 0, 0, 8'h00);
    chk(l_we == 0, "R6 all-masked flush dropped", l_we, 0);
    idle(2);
  endtask

  task automatic t_rst_err();
    step(1, 0, 0, 8'h00);
    step(0, 0, 0, 8'h00);
    step(1, 0, 0, 8'h00);
    chk(l_err == 1, "R7 one low cycle flagged", l_err, 1);
    step(1, 0, 0, 8'h00);
    chk(l_err == 0, "R7 held high not flagged", l_err, 0);
    idle(2);
    step(1, 0, 0, 8'h00);
    chk(l_err == 0, "R7 two low cycles ok", l_err, 0);
    idle(2);
  endtask

  task automatic t_short();
    for (int i = 0; i < MINR-1; i++) step(0, 1, 1, 8'(i));
    step(0, 0, 0, 8'h00);
    step(1, 0, 0, 8'h00);
    chk(l_short == 1, "R8 MIN_RUN-1 writes flagged", l_short, 1);
    idle(2);
    for (int i = 0; i < MINR; i++) step(0, 1, 1, 8'(i));
    step(1, 0, 0, 8'h00);
    chk(l_short == 0, "R8 MIN_RUN writes ok", l_short, 0);
    idle(2);
  endtask

  task automatic t_wrap();
    bit ok;
    for (int i = 0; i < DEPTH; i++) step(0, 1, 1, 8'((i * 7) ^ 8'h5A));
    chk(l_we == 1 && l_line == 6'd63, "R9 last line commit", l_line, 63);
    chk(wr_ptr == 0, "R9 pointer wrapped", wr_ptr, 0);
    ok = 1;
    for (int i = 0; i < DEPTH; i++) if (mem[i] != 8'((i * 7) ^ 8'h5A)) ok = 0;
    chk(ok, "R9 full field contents", ok, 1);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_first_reset();
    t_full_line();
    t_we_hold();
    t_mask();
    t_partial();
    t_rst_err();
    t_short();
    t_wrap();
    done = 1;
    summary();
    $finish;
  end
endmodule